// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Interrupt Detection

This block is a general-purpose I/O controller for sixteen pins, reached through a simple 32-bit register bus. Software sets a value for each line and chooses for each line whether the pad drives that value or leaves the pin as an input. The controller samples every pin through a two-stage synchronizer, and software reads the sampled levels back.

Each line also has its own interrupt detector. A 3-bit style code selects what the detector looks for: a high level, a low level, a rising edge, a falling edge, or any change. A detected event sets a sticky status bit, and software clears the bit by writing a one to it. The status bits of the thirteen lowest lines drive dedicated active-high interrupt wires. A clock-control word and a debounce-select word are kept as plain storage, so that software can read back what it wrote.

The bus uses byte addresses and whole 32-bit words. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio16_irq`

## Requirements
- R1: After reset, the registers read as follows. Data (0x00) is 0. Direction (0x04) is 0x0000FFFF, so every line is an input and `pin_drive` is 0. Status (0x0C) is 0. Both style words (0x10, 0x14) are 0. Debounce select (0x1C) is 0. Clock control (0x18) reads the parameter `CLK_CTRL_RST`, whose default is 0x01FF01FF.
- R2: `pin_out` equals bits [15:0] of the data register. Bit i of `pin_drive` is the inverse of direction bit i: a direction bit of 1 makes line i an input, and 0 drives it.
- R3: Reading 0x08 returns the pin levels in bits [15:0], with bits [31:16] at 0. A pin change shows up in this read after two rising clock edges, and not after only one.
- R4: Line n (0 to 7) takes its style from bits [3n+2:3n] of word 0x10. Line n+8 takes its style from the same bits of word 0x14. Style codes: 0 is level high, 1 is level low, 2 is rising edge, 3 is falling edge, 4 is any edge. Codes 5 to 7 never set status.
- R5: Under a level style, a status bit that is cleared while the synchronized pin is still at its active level sets again.
- R6: Under an edge style, a status bit sets once per qualifying transition of the synchronized pin. After a clear it stays 0 while the pin holds steady.
- R7: Writing a 1 to bit i of 0x0C clears status bit i. Writing a 0 leaves it unchanged. If a detection and a clear of the same bit fall in the same cycle, the detection wins and the bit stays set.
- R8: `irq_line[i]` equals status bit i for lines 0 to 12. Lines 13 to 15 have status bits but no wire.
- R9: Bits [31:24] of both style words read as 0 whatever was written. The clock-control and debounce-select words store all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output data to the pads |
| pin_drive | output | 16 | Pad drive enable, 1 = driven |
| irq_line | output | 13 | Active-high interrupt wires for lines 0 to 12 |

## Verification
A corrupted synchronizer stage or edge memory shows up as a wrong level in the input word, or as a missing or spurious status bit. Either becomes visible within three clock edges of a pin change. A wrong style field or a wrong field position sets status on the wrong line or with the wrong polarity, and the same status read exposes it on the matching `irq_line` wire. A broken clear or a broken priority shows up right away: a level bit that drops while its pin is still active, or an edge bit that comes back with no new transition.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

  localparam int STYLE_W = 3;

  typedef enum logic [STYLE_W-1:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } style_e;

  // word indices (byte address bits [4:2])
  localparam logic [2:0] W_DATA  = 3'd0;
  localparam logic [2:0] W_DIR   = 3'd1;
  localparam logic [2:0] W_LEVEL = 3'd2;
  localparam logic [2:0] W_STAT  = 3'd3;
  localparam logic [2:0] W_STY_A = 3'd4;
  localparam logic [2:0] W_STY_B = 3'd5;
  localparam logic [2:0] W_CLK   = 3'd6;
  localparam logic [2:0] W_DEB   = 3'd7;

  // detection of one line from its current and previous synchronized sample
  function automatic logic style_hit(logic [STYLE_W-1:0] sty, logic cur, logic prev);
    case (sty)
      STY_LVL_HI: return cur;
      STY_LVL_LO: return ~cur;
      STY_RISE:   return cur & ~prev;
      STY_FALL:   return ~cur & prev;
      STY_ANY:    return cur ^ prev;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic is_edge_style(logic [STYLE_W-1:0] sty);
    return (sty == STY_RISE) || (sty == STY_FALL) || (sty == STY_ANY);
  endfunction

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

  // cycles since reset, so the check never looks back into reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r3_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio16_detect.sv
module gpio16_detect
  import gpio16_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         cur,
  input  logic [LINES*STYLE_W-1:0] styles,
  output logic [LINES-1:0]         hit
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STYLE_W-1:0] sty;
    assign sty    = styles[i*STYLE_W +: STYLE_W];
    assign hit[i] = style_hit(sty, cur[i], prev_q[i]);

    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (sty > 3'd4) |-> !hit[i]);

    a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge_style(sty) && hit[i]) |-> (cur[i] != prev_q[i]));
  end

endmodule

// File: rtl/gpio16_status.sv
module gpio16_status #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hit,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] status
);
  logic [LINES-1:0] status_q;

  // a detection in the same cycle as a clear keeps the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | hit;
  end

  assign status = status_q;

  a_r7_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~hit)) |=> ((status & $past(clr & ~hit)) == '0));

  a_r7_sticky_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((~status) & $past(status & ~clr)) == '0));

  a_r5_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio16_irq.sv
module gpio16_irq
  import gpio16_pkg::*;
#(
  parameter int          NUM_LINES    = 16,
  parameter int          NUM_IRQ      = 13,
  parameter int          DW           = 32,
  parameter int          AW           = 5,
  parameter logic [31:0] CLK_CTRL_RST = 32'h01FF_01FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_drive,
  output logic [NUM_IRQ-1:0]   irq_line
);
  localparam int LINES_PER_WORD = 8;
  localparam int STY_BITS       = LINES_PER_WORD * STYLE_W;
  localparam int PAD_W          = DW - NUM_LINES;
  localparam int STY_PAD_W      = DW - STY_BITS;

  logic [2:0] widx;
  assign widx = bus_addr[AW-1:2];

  logic [NUM_LINES-1:0]         data_q;
  logic [NUM_LINES-1:0]         dir_q;
  logic [NUM_LINES*STYLE_W-1:0] sty_q;
  logic [DW-1:0]                clk_q;
  logic [DW-1:0]                deb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      sty_q  <= '0;
      clk_q  <= CLK_CTRL_RST;
      deb_q  <= '0;
    end else if (bus_wr) begin
      case (widx)
        W_DATA:  data_q <= bus_wdata[NUM_LINES-1:0];
        W_DIR:   dir_q  <= bus_wdata[NUM_LINES-1:0];
        W_STY_A: sty_q[STY_BITS-1:0] <= bus_wdata[STY_BITS-1:0];
        W_STY_B: sty_q[2*STY_BITS-1:STY_BITS] <= bus_wdata[STY_BITS-1:0];
        W_CLK:   clk_q  <= bus_wdata;
        W_DEB:   deb_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  logic [NUM_LINES-1:0] level;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] clr;
  logic [NUM_LINES-1:0] status;

  assign clr = (bus_wr && widx == W_STAT) ? bus_wdata[NUM_LINES-1:0] : '0;

  gpio16_sync #(.W(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (level)
  );

  gpio16_detect #(.LINES(NUM_LINES)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (level),
    .styles(sty_q),
    .hit   (hit)
  );

  gpio16_status #(.LINES(NUM_LINES)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .clr   (clr),
    .status(status)
  );

  always_comb begin
    case (widx)
      W_DATA:  bus_rdata = {{PAD_W{1'b0}}, data_q};
      W_DIR:   bus_rdata = {{PAD_W{1'b0}}, dir_q};
      W_LEVEL: bus_rdata = {{PAD_W{1'b0}}, level};
      W_STAT:  bus_rdata = {{PAD_W{1'b0}}, status};
      W_STY_A: bus_rdata = {{STY_PAD_W{1'b0}}, sty_q[STY_BITS-1:0]};
      W_STY_B: bus_rdata = {{STY_PAD_W{1'b0}}, sty_q[2*STY_BITS-1:STY_BITS]};
      W_CLK:   bus_rdata = clk_q;
      default: bus_rdata = deb_q;
    endcase
  end

  assign pin_out   = data_q;
  assign pin_drive = ~dir_q;
  assign irq_line  = status[NUM_IRQ-1:0];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:NUM_LINES]};

  a_r2_drive_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == W_DIR) |=> (pin_drive == ~$past(bus_wdata[NUM_LINES-1:0])));

endmodule

// File: tb/gpio16_irq_bench.sv
module gpio16_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_drive;
  logic [12:0] irq_line;

  int total = 0;
  int fails = 0;
  logic [23:0] shadow [2];

  always #10 clk = ~clk;

  gpio16_irq u_gpio16_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_drive(pin_drive), .irq_line(irq_line)
  );

  // {line[3:0], style[2:0], level_before, level_after, expected_status}
  localparam logic [9:0] VEC [13] = '{
    {4'd0,  3'd0, 1'b0, 1'b1, 1'b1},
    {4'd3,  3'd0, 1'b0, 1'b0, 1'b0},
    {4'd5,  3'd1, 1'b1, 1'b0, 1'b1},
    {4'd9,  3'd1, 1'b1, 1'b1, 1'b0},
    {4'd2,  3'd2, 1'b0, 1'b1, 1'b1},
    {4'd11, 3'd2, 1'b1, 1'b0, 1'b0},
    {4'd14, 3'd3, 1'b1, 1'b0, 1'b1},
    {4'd7,  3'd3, 1'b0, 1'b1, 1'b0},
    {4'd12, 3'd4, 1'b0, 1'b1, 1'b1},
    {4'd13, 3'd4, 1'b1, 1'b0, 1'b1},
    {4'd4,  3'd5, 1'b0, 1'b1, 1'b0},
    {4'd10, 3'd7, 1'b1, 1'b0, 1'b0},
    {4'd15, 3'd6, 1'b0, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_style(int line, logic [2:0] s);
    int w = line / 8;
    int f = line % 8;
    shadow[w][3*f +: 3] = s;
    wr(w == 0 ? 5'h10 : 5'h14, {8'h00, shadow[w]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    shadow[0] = '0; shadow[1] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(5'h00, v); chk("R1 data", v, 32'h0);
    rd(5'h04, v); chk("R1 dir", v, 32'h0000FFFF);
    rd(5'h0C, v); chk("R1 status", v, 32'h0);
    rd(5'h10, v); chk("R1 style A", v, 32'h0);
    rd(5'h14, v); chk("R1 style B", v, 32'h0);
    rd(5'h18, v); chk("R1 clock ctrl", v, 32'h01FF01FF);
    rd(5'h1C, v); chk("R1 debounce", v, 32'h0);
    chk("R1 pin_drive", {16'h0, pin_drive}, 32'h0);

    // R2 output path
    wr(5'h00, 32'hFFFF_A5C3);
    wr(5'h04, 32'h0000_00FF);
    chk("R2 pin_out", {16'h0, pin_out}, 32'h0000A5C3);
    chk("R2 pin_drive", {16'h0, pin_drive}, 32'h0000FF00);
    wr(5'h04, 32'h0000_FFFF);

    // R3 input synchronizer latency and upper bits
    pin_in = 16'h1234;
    tick(1); rd(5'h08, v); chk("R3 one edge", v, 32'h0);
    tick(1); rd(5'h08, v); chk("R3 two edges", v, 32'h00001234);
    pin_in = 16'h0;
    tick(4);

    // R9 style word width, plain words
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, v); chk("R9 style B mask", v, 32'h00FFFFFF);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'hDEAD_BEEF); rd(5'h18, v); chk("R9 clock word", v, 32'hDEADBEEF);
    wr(5'h1C, 32'h1357_9BDF); rd(5'h1C, v); chk("R9 debounce word", v, 32'h13579BDF);
    wr(5'h0C, 32'hFFFF);

    // R4 R6 R8 vector table
    for (int k = 0; k < 13; k++) begin
      int          ln  = int'(VEC[k][9:6]);
      logic [2:0]  sty = VEC[k][5:3];
      logic        p0  = VEC[k][2];
      logic        p1  = VEC[k][1];
      logic        exp = VEC[k][0];
      pin_in = p0 ? (16'h1 << ln) : 16'h0;
      tick(4);
      set_style(ln, sty);
      tick(4);
      wr(5'h0C, 32'hFFFF);
      pin_in = p1 ? (16'h1 << ln) : 16'h0;
      tick(4);
      rd(5'h0C, v);
      chk($sformatf("R4 vector %0d line %0d", k, ln), {31'h0, v[ln]}, {31'h0, exp});
      if (ln < 13)
        chk($sformatf("R8 wire line %0d", ln), {31'h0, irq_line[ln]}, {31'h0, exp});
    end

    // R5 level re-assert while active
    pin_in = 16'h0;
    set_style(1, 3'd0);
    pin_in = 16'h0002;
    tick(4);
    wr(5'h0C, 32'h0002);
    rd(5'h0C, v); chk("R5 level stays set", {31'h0, v[1]}, 32'h1);
    pin_in = 16'h0;
    tick(4);
    wr(5'h0C, 32'h0002);
    rd(5'h0C, v); chk("R5 level inactive clears", {31'h0, v[1]}, 32'h0);

    // R6 edge stays clear
    set_style(6, 3'd2);
    tick(2);
    wr(5'h0C, 32'hFFFF);
    pin_in = 16'h0040;
    tick(4);
    rd(5'h0C, v); chk("R6 rise sets", {31'h0, v[6]}, 32'h1);
    wr(5'h0C, 32'h0040);
    tick(4);
    rd(5'h0C, v); chk("R6 steady stays clear", {31'h0, v[6]}, 32'h0);
    pin_in = 16'h0;
    tick(4);
    pin_in = 16'h0040;
    tick(4);
    rd(5'h0C, v); chk("R6 new edge sets", {31'h0, v[6]}, 32'h1);

    // R7 zero writes leave status alone
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); chk("R7 zero write", {31'h0, v[6]}, 32'h1);
    wr(5'h0C, 32'hFFBF);
    rd(5'h0C, v); chk("R7 other bits write", {31'h0, v[6]}, 32'h1);

    // R8 wires mirror status
    rd(5'h0C, v);
    chk("R8 wires equal status", {19'h0, irq_line}, {19'h0, v[12:0]});

    summary();
    $finish;
  end

endmodule